// File: doc/BRIEF.md
# Disk Controller Host Handshake Engine

This block is the host-facing side of a floppy-style disk controller. A host reaches it over a byte-wide register bus with separate read and write strobes. The block holds a main status byte, a data-rate byte, a drive-output byte and a data port. Behind the data port sits a small command buffer. The status byte is the only record of which phase the controller is in. Its request-for-master (RQM) and data-direction (DIO) bits decide whether the host may touch the data port.

A command is written one byte at a time. Its first byte sets how many bytes follow. Read and write commands then run a stub transfer of a programmed number of bytes. The bytes move either by DMA, one byte per `dma_ack` beat, or by programmed I/O through the data port. A result phase follows, and the host reads the result bytes back. The interrupt line rises when a programmed-I/O transfer starts and when a transfer ends. It also rises when the controller resets itself.

Accesses to the status and data-rate registers have side effects on the power-down and reset state. A controller reset can be requested from the drive-output register or from the data-rate register.

Top module: `disk_host_handshake`

## Requirements
- R1: Register map: offset 2 is the drive-output register (read/write), offset 3 reads back the data-rate register, offset 4 reads the status byte and writes the data-rate register, offset 5 is the data port, and any other offset reads 0. Status bits: RQM = bit 7, DIO = bit 6, NONDMA = bit 5, CMDBUSY = bit 4, bits 3..0 read 0. After `rst_n` is low: status is 0x80, the drive-output register is 0x0C (run = bit 2, DMA enable = bit 3), the data-rate register is 0x00, and `irq` and `dma_req` are low.
- R2: A data-port read is accepted only when RQM and DIO are both 1. Otherwise it returns 0x00 and leaves every state unchanged.
- R3: A data-port write is accepted only when RQM = 1, DIO = 0 and the run bit (drive-output bit 2) is 1. Otherwise it is dropped.
- R4: In the command phase, bits 4..0 of the first byte are the opcode. 0x05 (write) and 0x06 (read) take 9 bytes. 0x03 (mode set) takes 3 bytes; bit 0 of its third byte selects programmed I/O and it returns to the command phase with no result. 0x08 (interrupt query) takes 1 byte. Any other opcode takes 1 byte and gives a 1-byte result of 0x80. CMDBUSY sets when the first command byte is accepted.
- R5: The result phase shows status 0xD0. Once its last byte is read, CMDBUSY and DIO clear and the status returns to 0x80.
- R6: Starting a transfer sets CMDBUSY. When drive-output bit 3 is 1 and programmed I/O is not selected, the transfer uses DMA: RQM clears, `dma_req` rises and the status reads 0x10.
- R7: Otherwise the transfer uses programmed I/O: NONDMA sets, DIO sets for a read (status 0xF0) but not for a write (status 0xB0), and `irq` rises.
- R8: The transfer length is bits 3..0 of the ninth command byte plus 1. A read transfer delivers bytes equal to their index 0, 1, 2, and so on. The transfer ends when the beat count reaches the length. NONDMA then clears, RQM and DIO set, a 7-byte result phase starts and `irq` rises.
- R9: In DMA mode, each cycle with `dma_req` and `dma_ack` high moves one byte. `dma_rdata` carries the index byte and `dma_wdata` is taken for writes. `dma_req` falls when the transfer ends.
- R10: The transfer result bytes are, in order: 0x20, the XOR of all bytes moved, 0x00, command byte 2, command byte 3 XOR the multi-track flag, command byte 4, command byte 5. The multi-track flag is bit 7 of the first command byte.
- R11: Any accepted data-port read or write clears `irq`.
- R12: A status read clears data-rate bit 6 (power-down) and forces drive-output bit 2 to 1, without a controller reset.
- R13: Writing drive-output bit 2 from 0 to 1 resets the controller. Status becomes 0x80, the buffer position clears, programmed I/O is deselected and `irq` rises. An interrupt query then returns 0xC0, 0x00. After a transfer has ended, the query returns 0x20, 0x00.
- R14: Writing the data-rate register with bit 6 set resets the controller as in R13, and the written value is stored. A write with bit 6 clear is only stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA transfer in progress |
| dma_ack | input | 1 | One DMA byte beat |
| dma_wdata | input | 8 | DMA byte toward the controller |
| dma_rdata | output | 8 | DMA byte from the controller |

## Verification
A wrong phase in this block shows in the status byte on the very next read of offset 4. It also shows in the accept-or-drop outcome of the next data-port access: a dropped command byte leaves the phase where it was, so the status read that follows gives it away. A position counter that is off by one shows in the index bytes of a read transfer, or ends a transfer one beat early or late. In either case the status after the final beat is wrong, and the XOR byte of the result is wrong too. The sweep covers every transfer length in both directions and both transfer modes, so a mistake in the length field or in the end-of-transfer compare shows up within one transaction.

// File: rtl/disk_hs_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the disk controller host handshake engine.
// Assumes a byte-wide host bus with at most eight register offsets.
package disk_hs_pkg;
    localparam logic [2:0] OFS_DOR     = 3'd2;
    localparam logic [2:0] OFS_RATE_RB = 3'd3;
    localparam logic [2:0] OFS_STAT    = 3'd4;
    localparam logic [2:0] OFS_DATA    = 3'd5;

    localparam int DOR_RUN = 2;
    localparam int DOR_DMA = 3;
    localparam int RATE_PD = 6;

    localparam logic [4:0] OP_MODESET = 5'h03;
    localparam logic [4:0] OP_WRITE   = 5'h05;
    localparam logic [4:0] OP_READ    = 5'h06;
    localparam logic [4:0] OP_QUERY   = 5'h08;

    localparam logic [7:0] ST0_XFER_END = 8'h20;
    localparam logic [7:0] ST0_RESET    = 8'hC0;
    localparam logic [7:0] RES_INVALID  = 8'h80;

    typedef enum logic [1:0] {PH_CMD, PH_XFER, PH_RESULT} phase_t;
    typedef enum logic [1:0] {RK_XFER, RK_QUERY, RK_INVALID} res_kind_t;

    // Total command length in bytes, selected by the opcode bits of the first byte.
    function automatic logic [3:0] cmd_length(input logic [4:0] opcode);
        case (opcode)
            OP_WRITE, OP_READ: cmd_length = 4'd9;
            OP_MODESET:        cmd_length = 4'd3;
            default:           cmd_length = 4'd1;
        endcase
    endfunction
endpackage

// File: rtl/dhs_host_regs.sv
`timescale 1ns/1ps
// Drive-output and data-rate registers with their access side effects.
// Raises a one-cycle controller reset request (combinational from the strobe)
// on a 0->1 write of the run bit or a data-rate write with power-down set.
// Assumes at most one register strobe targets each register per cycle.
module dhs_host_regs
    import disk_hs_pkg::*;
#(
    parameter bit DMA_DEFAULT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dor_wr,
    input  logic       rate_wr,
    input  logic       stat_rd,
    input  logic [7:0] wdata,
    output logic [7:0] dor,
    output logic [7:0] rate,
    output logic       soft_rst
);
    localparam logic [7:0] DOR_INIT = {4'b0000, DMA_DEFAULT, 1'b1, 2'b00};

    // Reset request: run-bit rising write or power-down data-rate write.
    assign soft_rst = (dor_wr && !dor[DOR_RUN] && wdata[DOR_RUN]) ||
                      (rate_wr && wdata[RATE_PD]);

    // Drive-output register: host writes, status read forces the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n)          dor <= DOR_INIT;
        else if (dor_wr)     dor <= wdata;
        else if (stat_rd)    dor[DOR_RUN] <= 1'b1;
    end

    // Data-rate register: host writes, status read clears power-down.
    always_ff @(posedge clk) begin
        if (!rst_n)          rate <= 8'h00;
        else if (rate_wr)    rate <= wdata;
        else if (stat_rd)    rate[RATE_PD] <= 1'b0;
    end

    // R12
    status_read_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !dor_wr && !rate_wr) |=> (dor[DOR_RUN] && !rate[RATE_PD]));

    // R14
    rate_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_wr |=> (rate == $past(wdata)));
endmodule

// File: rtl/dhs_cmd_buffer.sv
`timescale 1ns/1ps
// Command byte store: one write port and one asynchronous read port that
// share an index. Also exposes cell 0 (the opcode byte) directly.
// Assumes DEPTH is a power of two and at least the longest command.
module dhs_cmd_buffer #(
    parameter  int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wbyte,
    output logic [7:0]       head,
    output logic [7:0]       rbyte
);
    logic [7:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        // Cell storage: written when the shared index selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)                            cells[g] <= 8'h00;
            else if (we && idx == IDX_W'(g))       cells[g] <= wbyte;
        end
    end

    assign head  = cells[0];
    assign rbyte = cells[idx];
endmodule

// File: rtl/dhs_phase_ctrl.sv
`timescale 1ns/1ps
// Phase engine: command collection, stub transfer (DMA or programmed I/O),
// and result delivery. The stored status bits RQM/DIO/NONDMA/CMDBUSY
// are the phase record and gate every data-port access.
// Assumes the command buffer holds at least nine bytes.
module dhs_phase_ctrl
    import disk_hs_pkg::*;
#(
    parameter  int CMD_DEPTH = 16,
    parameter  int LEN_W     = 4,
    localparam int IDX_W     = $clog2(CMD_DEPTH),
    localparam int POS_W     = ((LEN_W + 1) > (IDX_W + 1)) ? (LEN_W + 1) : (IDX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             ctl_run,
    input  logic             dma_allow,
    input  logic             data_wr,
    input  logic             data_rd,
    input  logic [7:0]       wdata,
    input  logic [7:0]       cmd_head,
    input  logic [7:0]       cmd_rbyte,
    input  logic             dma_ack,
    input  logic [7:0]       dma_wdata,
    output logic [7:0]       status,
    output logic [7:0]       data_out,
    output logic             buf_we,
    output logic [IDX_W-1:0] buf_idx,
    output logic             irq,
    output logic             dma_req,
    output logic [7:0]       dma_rdata
);
    phase_t          phase;
    res_kind_t       res_kind;
    logic            rqm, dio, ndma, busy;
    logic            nd_flag, mt, dir_rd;
    logic [POS_W-1:0] pos, need;
    logic [7:0]      xor_acc, st0_lat;

    logic [POS_W-1:0] pos_nx, cmd_need, xfer_len;
    logic [7:0]      first, xfer_byte, beat_byte, res_byte;
    logic [4:0]      op;
    logic            wr_ok, rd_ok, cmd_done;
    logic            dma_beat, pio_beat, xfer_beat, xfer_end;
    logic            unused_bits;

    // Access gating from the stored status bits.
    assign wr_ok = data_wr && ctl_run && rqm && !dio;
    assign rd_ok = data_rd && rqm && dio;

    // Command decode: the opcode byte is the incoming byte when at position 0.
    assign pos_nx      = pos + 1'b1;
    assign first       = (pos == '0) ? wdata : cmd_head;
    assign op          = first[4:0];
    assign cmd_need    = POS_W'(cmd_length(op));
    assign cmd_done    = wr_ok && (phase == PH_CMD) && (pos_nx == cmd_need);
    assign xfer_len    = POS_W'(wdata[LEN_W-1:0]) + 1'b1;
    assign unused_bits = ^first[6:5];

    // Transfer beats from either the DMA side or the data port.
    assign dma_req   = (phase == PH_XFER) && !ndma;
    assign dma_beat  = dma_req && dma_ack;
    assign pio_beat  = (phase == PH_XFER) && ndma && (wr_ok || rd_ok);
    assign xfer_beat = dma_beat || pio_beat;
    assign xfer_byte = 8'(pos);
    assign beat_byte = dir_rd ? xfer_byte : (dma_beat ? dma_wdata : wdata);
    assign xfer_end  = xfer_beat && (pos_nx == need);
    assign dma_rdata = xfer_byte;

    // Buffer index: write slot during commands, echo slot (pos-1) during results.
    assign buf_we  = wr_ok && (phase == PH_CMD);
    assign buf_idx = (phase == PH_RESULT) ? IDX_W'(pos - 1'b1) : IDX_W'(pos);

    // Result byte selection by result kind and position.
    always_comb begin
        res_byte = 8'h00;
        case (res_kind)
            RK_XFER: begin
                case (pos)
                    POS_W'(0): res_byte = ST0_XFER_END;
                    POS_W'(1): res_byte = xor_acc;
                    POS_W'(2): res_byte = 8'h00;
                    POS_W'(4): res_byte = cmd_rbyte ^ {7'b0, mt};
                    default:   res_byte = cmd_rbyte;
                endcase
            end
            RK_QUERY:   res_byte = (pos == '0) ? st0_lat : 8'h00;
            default:    res_byte = RES_INVALID;
        endcase
    end

    assign data_out = rd_ok ? ((phase == PH_RESULT) ? res_byte : xfer_byte) : 8'h00;
    assign status   = {rqm, dio, ndma, busy, 4'b0000};

    // Phase engine state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_CMD;  res_kind <= RK_INVALID;
            rqm <= 1'b1;  dio <= 1'b0;  ndma <= 1'b0;  busy <= 1'b0;
            pos <= '0;  need <= '0;  irq <= 1'b0;
            nd_flag <= 1'b0;  mt <= 1'b0;  dir_rd <= 1'b0;
            xor_acc <= 8'h00;  st0_lat <= ST0_RESET;
        end else if (soft_rst) begin
            phase <= PH_CMD;  res_kind <= RK_INVALID;
            rqm <= 1'b1;  dio <= 1'b0;  ndma <= 1'b0;  busy <= 1'b0;
            pos <= '0;  need <= '0;  irq <= 1'b1;
            nd_flag <= 1'b0;  mt <= 1'b0;  dir_rd <= 1'b0;
            xor_acc <= 8'h00;  st0_lat <= ST0_RESET;
        end else begin
            if (wr_ok || rd_ok) irq <= 1'b0;
            case (phase)
                PH_CMD: begin
                    if (wr_ok) begin
                        busy <= 1'b1;
                        pos  <= pos_nx;
                    end
                    if (cmd_done) begin
                        pos <= '0;
                        case (op)
                            OP_MODESET: begin
                                nd_flag <= wdata[0];
                                busy    <= 1'b0;
                            end
                            OP_QUERY: begin
                                res_kind <= RK_QUERY;
                                need     <= POS_W'(2);
                                phase    <= PH_RESULT;
                                dio      <= 1'b1;
                            end
                            OP_WRITE, OP_READ: begin
                                mt      <= first[7];
                                dir_rd  <= (op == OP_READ);
                                need    <= xfer_len;
                                xor_acc <= 8'h00;
                                phase   <= PH_XFER;
                                if (dma_allow && !nd_flag) begin
                                    rqm <= 1'b0;
                                end else begin
                                    ndma <= 1'b1;
                                    dio  <= (op == OP_READ);
                                    irq  <= 1'b1;
                                end
                            end
                            default: begin
                                res_kind <= RK_INVALID;
                                need     <= POS_W'(1);
                                phase    <= PH_RESULT;
                                dio      <= 1'b1;
                            end
                        endcase
                    end
                end
                PH_XFER: begin
                    if (xfer_beat) begin
                        xor_acc <= xor_acc ^ beat_byte;
                        pos     <= pos_nx;
                    end
                    if (xfer_end) begin
                        pos      <= '0;
                        need     <= POS_W'(7);
                        phase    <= PH_RESULT;
                        res_kind <= RK_XFER;
                        ndma     <= 1'b0;
                        rqm      <= 1'b1;
                        dio      <= 1'b1;
                        irq      <= 1'b1;
                        st0_lat  <= ST0_XFER_END;
                    end
                end
                PH_RESULT: begin
                    if (rd_ok) begin
                        pos <= pos_nx;
                        if (pos_nx == need) begin
                            pos   <= '0;
                            need  <= '0;
                            phase <= PH_CMD;
                            busy  <= 1'b0;
                            dio   <= 1'b0;
                        end
                    end
                end
                default: phase <= PH_CMD;
            endcase
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (status == 8'h80 && irq && !dma_req));

    // R2
    read_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !(rqm && dio) && !soft_rst && !dma_ack) |=> ($stable(pos) && $stable(phase)));

    // R3
    write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !(ctl_run && rqm && !dio) && !soft_rst && !dma_ack) |=> ($stable(pos) && $stable(phase)));

    // R5
    result_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RESULT) |-> (rqm && dio && busy && !ndma));

    // R6
    dma_blocks_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (!rqm && busy));

    // R7
    pio_flag_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ndma |-> (phase == PH_XFER && rqm && busy));

    // R8
    xfer_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end && !soft_rst) |=> (irq && status == 8'hD0));
endmodule

// File: rtl/disk_host_handshake.sv
`timescale 1ns/1ps
// Top of the disk controller host handshake engine: decodes the register
// offsets, muxes read data, and connects the register block, the command
// buffer and the phase engine. Assumes one bus access per strobe cycle.
module disk_host_handshake
    import disk_hs_pkg::*;
#(
    parameter int CMD_DEPTH   = 16,
    parameter int LEN_W       = 4,
    parameter bit DMA_DEFAULT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    output logic       dma_req,
    input  logic       dma_ack,
    input  logic [7:0] dma_wdata,
    output logic [7:0] dma_rdata
);
    localparam int IDX_W = $clog2(CMD_DEPTH);

    logic             dor_wr, rate_wr, stat_rd, data_wr, data_rd, soft_rst;
    logic [7:0]       dor, rate, status, data_out, cmd_head, cmd_rbyte;
    logic             buf_we;
    logic [IDX_W-1:0] buf_idx;

    // Offset decode of the bus strobes.
    assign dor_wr  = bus_wr && (bus_addr == OFS_DOR);
    assign rate_wr = bus_wr && (bus_addr == OFS_STAT);
    assign stat_rd = bus_rd && (bus_addr == OFS_STAT);
    assign data_wr = bus_wr && (bus_addr == OFS_DATA);
    assign data_rd = bus_rd && (bus_addr == OFS_DATA);

    dhs_host_regs #(.DMA_DEFAULT(DMA_DEFAULT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .dor_wr   (dor_wr),
        .rate_wr  (rate_wr),
        .stat_rd  (stat_rd),
        .wdata    (bus_wdata),
        .dor      (dor),
        .rate     (rate),
        .soft_rst (soft_rst)
    );

    dhs_cmd_buffer #(.DEPTH(CMD_DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (buf_we),
        .idx   (buf_idx),
        .wbyte (bus_wdata),
        .head  (cmd_head),
        .rbyte (cmd_rbyte)
    );

    dhs_phase_ctrl #(.CMD_DEPTH(CMD_DEPTH), .LEN_W(LEN_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .ctl_run   (dor[DOR_RUN]),
        .dma_allow (dor[DOR_DMA]),
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .wdata     (bus_wdata),
        .cmd_head  (cmd_head),
        .cmd_rbyte (cmd_rbyte),
        .dma_ack   (dma_ack),
        .dma_wdata (dma_wdata),
        .status    (status),
        .data_out  (data_out),
        .buf_we    (buf_we),
        .buf_idx   (buf_idx),
        .irq       (irq),
        .dma_req   (dma_req),
        .dma_rdata (dma_rdata)
    );

    // Read data mux by offset.
    always_comb begin
        case (bus_addr)
            OFS_DOR:     bus_rdata = dor;
            OFS_RATE_RB: bus_rdata = rate;
            OFS_STAT:    bus_rdata = status;
            OFS_DATA:    bus_rdata = data_out;
            default:     bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: tb/disk_host_handshake_tb.sv
`timescale 1ns/1ps
module disk_host_handshake_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, dma_req;
    logic       dma_ack = 1'b0;
    logic [7:0] dma_wdata = 8'h00;
    logic [7:0] dma_rdata;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    localparam logic [2:0] A_DOR = 3'd2, A_RRB = 3'd3, A_STAT = 3'd4, A_DATA = 3'd5;

    always #2.5 clk = ~clk;

    disk_host_handshake u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req),
        .dma_ack(dma_ack), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic expect_rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check8(tag, v, exp);
    endtask

    task automatic set_mode(input bit pio);
        wr(A_DATA, 8'h03); wr(A_DATA, 8'h00); wr(A_DATA, {7'b0, pio});
        expect_rd("R4 mode set returns to command phase", A_STAT, 8'h80);
    endtask

    // One full transaction: command, transfer, result; expected values computed here.
    task automatic do_xfer(input logic [4:0] op, input bit mt, input int len,
                           input bit dma_exp, input bit probe);
        logic [7:0] cb [9];
        logic [7:0] xr, d, start_st, v;
        bit rd_dir;
        rd_dir = (op == 5'h06);
        cb[0] = {mt, 2'b00, op}; cb[1] = 8'h00; cb[2] = 8'(8'h30 + len);
        cb[3] = 8'h02; cb[4] = 8'(len * 3); cb[5] = 8'h02;
        cb[6] = 8'h12; cb[7] = 8'h1B; cb[8] = 8'(len - 1);
        wr(A_DATA, cb[0]);
        expect_rd("R4 busy after first command byte", A_STAT, 8'h90);
        for (int k = 1; k < 9; k++) wr(A_DATA, cb[k]);
        start_st = dma_exp ? 8'h10 : (rd_dir ? 8'hF0 : 8'hB0);
        expect_rd(dma_exp ? "R6 DMA start status" : "R7 PIO start status", A_STAT, start_st);
        check8(dma_exp ? "R6 dma_req high" : "R7 dma_req low", {7'b0, dma_req}, {7'b0, dma_exp});
        check8(dma_exp ? "R6 no irq at DMA start" : "R7 irq at PIO start", {7'b0, irq}, {7'b0, !dma_exp});
        xr = 8'h00;
        for (int i = 0; i < len; i++) begin
            d = rd_dir ? 8'(i) : 8'((len * 7 + i * 13) & 8'hFF);
            if (i == len - 1)
                expect_rd("R8 no early end of transfer", A_STAT, start_st);
            if (dma_exp) begin
                if (probe && i == 2) begin
                    wr(A_DATA, 8'hEE);
                    expect_rd("R2 data read blocked during DMA", A_DATA, 8'h00);
                end
                @(negedge clk);
                dma_ack = 1'b1; dma_wdata = d;
                #1 if (rd_dir) check8("R9 DMA read byte", dma_rdata, d);
                @(negedge clk);
                dma_ack = 1'b0;
            end else if (rd_dir) begin
                rd(A_DATA, v);
                check8("R8 PIO read byte", v, d);
            end else begin
                wr(A_DATA, d);
            end
            xr = xr ^ d;
            if (i == 0 && !dma_exp && len > 1)
                check8("R11 irq cleared by data access", {7'b0, irq}, 8'h00);
        end
        expect_rd("R8 result phase status", A_STAT, 8'hD0);
        check8("R8 irq at transfer end", {7'b0, irq}, 8'h01);
        check8("R9 dma_req low at end", {7'b0, dma_req}, 8'h00);
        expect_rd("R10 result 0", A_DATA, 8'h20);
        expect_rd("R10 result xor", A_DATA, xr);
        expect_rd("R10 result 2", A_DATA, 8'h00);
        expect_rd("R10 result 3", A_DATA, cb[2]);
        expect_rd("R10 result 4 multi-track", A_DATA, cb[3] ^ {7'b0, mt});
        expect_rd("R10 result 5", A_DATA, cb[4]);
        expect_rd("R10 result 6", A_DATA, cb[5]);
        expect_rd("R5 back to command phase", A_STAT, 8'h80);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        expect_rd("R1 status after reset", A_STAT, 8'h80);
        expect_rd("R1 output register after reset", A_DOR, 8'h0C);
        expect_rd("R1 data-rate after reset", A_RRB, 8'h00);
        expect_rd("R1 unused offset", 3'd7, 8'h00);
        check8("R1 irq low", {7'b0, irq}, 8'h00);
        check8("R1 dma_req low", {7'b0, dma_req}, 8'h00);

        // R2 read in command phase
        expect_rd("R2 data read in command phase", A_DATA, 8'h00);
        expect_rd("R2 status unchanged", A_STAT, 8'h80);

        // R4 invalid opcode, R3 write dropped in result phase
        wr(A_DATA, 8'h1F);
        expect_rd("R5 result status for invalid opcode", A_STAT, 8'hD0);
        wr(A_DATA, 8'h55);
        expect_rd("R4 invalid result byte (R3 dropped write)", A_DATA, 8'h80);
        expect_rd("R5 command phase after one result byte", A_STAT, 8'h80);

        // Programmed I/O sweep, both directions, all lengths
        set_mode(1'b1);
        for (int l = 1; l <= 16; l++) do_xfer(5'h05, l[0], l, 1'b0, 1'b0);
        for (int l = 1; l <= 16; l++) do_xfer(5'h06, l[0], l, 1'b0, 1'b0);

        // R13 query after transfer
        wr(A_DATA, 8'h08);
        expect_rd("R13 query after transfer", A_DATA, 8'h20);
        expect_rd("R13 query second byte", A_DATA, 8'h00);
        expect_rd("R5 status after query", A_STAT, 8'h80);

        // DMA sweep
        set_mode(1'b0);
        for (int l = 1; l <= 16; l++) do_xfer(5'h05, l[1], l, 1'b1, l >= 4);
        for (int l = 1; l <= 16; l++) do_xfer(5'h06, l[1], l, 1'b1, l >= 4);

        // R6 DMA disabled in the output register falls back to PIO
        wr(A_DOR, 8'h04);
        do_xfer(5'h05, 1'b0, 5, 1'b0, 1'b0);
        do_xfer(5'h06, 1'b1, 3, 1'b0, 1'b0);
        wr(A_DOR, 8'h0C);
        expect_rd("R13 run bit kept high gives no reset", A_STAT, 8'h80);

        // R3 run bit low drops writes; R12 status read forces it high
        wr(A_DOR, 8'h08);
        wr(A_DATA, 8'h1F);
        expect_rd("R3 output register held", A_DOR, 8'h08);
        expect_rd("R3 write dropped while run bit low", A_STAT, 8'h80);
        expect_rd("R12 status read sets run bit", A_DOR, 8'h0C);
        check8("R12 no reset from status read", {7'b0, irq}, 8'h00);

        // R13 run-bit edge reset in mid command
        wr(A_DATA, 8'h05);
        expect_rd("R4 partial command busy", A_STAT, 8'h90);
        wr(A_DOR, 8'h08);
        wr(A_DOR, 8'h0C);
        expect_rd("R13 status after edge reset", A_STAT, 8'h80);
        check8("R13 irq after edge reset", {7'b0, irq}, 8'h01);
        wr(A_DATA, 8'h08);
        check8("R11 irq cleared by command write", {7'b0, irq}, 8'h00);
        expect_rd("R13 query after reset", A_DATA, 8'hC0);
        expect_rd("R13 query second byte", A_DATA, 8'h00);
        do_xfer(5'h06, 1'b0, 2, 1'b1, 1'b0);

        // R14 data-rate write with and without power-down
        wr(A_DATA, 8'h06);
        wr(A_STAT, 8'h02);
        expect_rd("R14 plain rate write stored", A_RRB, 8'h02);
        expect_rd("R14 plain rate write keeps phase", A_STAT, 8'h90);
        wr(A_STAT, 8'h41);
        expect_rd("R14 power-down value stored", A_RRB, 8'h41);
        check8("R14 irq after power-down reset", {7'b0, irq}, 8'h01);
        expect_rd("R14 status after power-down reset", A_STAT, 8'h80);
        expect_rd("R12 power-down cleared by status read", A_RRB, 8'h01);
        rd(A_DATA, v);
        check8("R2 read after reset returns zero", v, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule